// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sensing

This block is a bank of up to 32 general-purpose lines behind a simple 32-bit register bus. Each line can be set up as a plain input or a plain output, or it can be handed to the interrupt logic. In that case the line has its own polarity select, its own choice of level or edge detection, and its own choice of single-edge or dual-edge triggering. Pad inputs pass through a two-flop synchronizer before any logic uses them. Pad drive is presented as separate output-data and output-enable vectors.

Edge events set sticky status bits. Software clears them by writing ones to an acknowledge register. Level-sensed lines show the qualified input level in their status bits. Interrupt enables are changed through two write ports: one port clears every enable whose data bit is written as zero, and the other sets every enable whose data bit is written as one. A single interrupt output is raised while any enabled line has status set. Bus reads are combinational and use byte offsets on `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every line is an input (`pad_oe` all zero), all enables are zero, all status bits are zero and `irq_o` is low.
- R2: Mode register (offset 0x00): a bit of 1 selects interrupt mode. `pad_oe` bit i is 1 only when mode bit i is 0 and direction bit i (offset 0x04) is 1. `pad_out` always equals the output-data register (offset 0x08).
- R3: A read of offset 0x0C returns `pad_in` through a two-flop synchronizer: a pin change becomes visible after the second rising clock edge.
- R4: In interrupt mode with trigger bit (offset 0x24) at 0, status bit i equals the synchronized pin XOR polarity bit i (offset 0x20, where 1 means active low), one edge later. An acknowledge write does not clear it.
- R5: In interrupt mode with trigger bit 1 and both-edge bit (offset 0x4C) at 0, polarity 0 latches rising edges and polarity 1 latches falling edges. Status is set on the third rising edge after the pin change and stays set until acknowledged.
- R6: With trigger bit 1 and both-edge bit 1, both rising and falling edges set status, whatever the polarity bit holds.
- R7: Writing offset 0x14 clears the edge status of every line whose data bit is 1. Bits written as 0 have no effect. An edge event in the same cycle as its clear leaves the bit set. Offset 0x14 reads as zero.
- R8: A write to offset 0x18 clears the enable of every line whose data bit is 0 and keeps the others. A write to offset 0x1C sets the enable of every line whose data bit is 1. Offset 0x18 reads the enables and offset 0x1C reads as zero.
- R9: `irq_o` is 1 exactly when the bitwise AND of status and enables is nonzero. Status is read at offset 0x10.
- R10: A line whose mode bit is 0 holds a status bit of 0.
- R11: Reads of unmapped offsets return zero, and writes to them (and to 0x0C, 0x10) change no register.
- R12: The mode, direction, output-data, polarity, trigger and both-edge registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | NLINES | Pad input levels (asynchronous) |
| pad_out | output | NLINES | Pad output data |
| pad_oe | output | NLINES | Pad output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The two functions that can fall in the same cycle are an edge event on a line and a software acknowledge of that same line. The bench raises a pin and issues the acknowledge write so that it is sampled on the third edge after the pin change, which is the edge that latches the event. It then requires that the status bit is still set. The random phase mixes pin toggles with acknowledge, mask and configuration writes on every cycle. A cycle model in the bench judges status and `irq_o` after each edge, so collisions of events with clears and with mode changes are also covered.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned DW = 32;

    localparam logic [7:0] OFS_MODE   = 8'h00;
    localparam logic [7:0] OFS_DIR    = 8'h04;
    localparam logic [7:0] OFS_DOUT   = 8'h08;
    localparam logic [7:0] OFS_DIN    = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_ACK    = 8'h14;
    localparam logic [7:0] OFS_MASK   = 8'h18;
    localparam logic [7:0] OFS_UNMASK = 8'h1C;
    localparam logic [7:0] OFS_POL    = 8'h20;
    localparam logic [7:0] OFS_TRIG   = 8'h24;
    localparam logic [7:0] OFS_BOTH   = 8'h4C;

    // software-visible configuration, one bit per line
    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] dir;
        logic [DW-1:0] dout;
        logic [DW-1:0] pol;
        logic [DW-1:0] trig;
        logic [DW-1:0] both;
        logic [DW-1:0] en;
    } cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] trig_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] status;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] ev_vec;
    logic [W-1:0] lvl_vec;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic now_q, was_q;
        assign now_q      = sync_i[i] ^ pol_i[i];
        assign was_q      = st_q.prev[i] ^ pol_i[i];
        assign lvl_vec[i] = now_q;
        assign ev_vec[i]  = both_i[i] ? (sync_i[i] ^ st_q.prev[i]) : (now_q & ~was_q);
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sync_i;
        st_d.status = mode_i & ((trig_i & (ev_vec | (st_q.status & ~ack_i)))
                              | (~trig_i & lvl_vec));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.status & $past(ack_i & mode_i & trig_i & ~ev_vec)) == '0);
    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(st_q.status & mode_i & trig_i & ~ack_i) & ~st_q.status) == '0);
    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status ^ $past(sync_i ^ pol_i)) & $past(mode_i & ~trig_i)) == '0);
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.status & ~$past(mode_i)) == '0);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq_o
);
    localparam logic [DW-1:0] LMASK = DW'((64'h1 << NLINES) - 64'h1);

    cfg_t            cfg_d, cfg_q;
    logic [DW-1:0]   wd;
    logic [DW-1:0]   ack;
    logic            cfg_wr_hit;
    logic [NLINES-1:0] pin_s;
    logic [NLINES-1:0] stat;

    assign wd = bus_wdata & LMASK;

    always_comb begin
        cfg_d      = cfg_q;
        ack        = '0;
        cfg_wr_hit = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:   begin cfg_d.mode = wd; cfg_wr_hit = 1'b1; end
                OFS_DIR:    begin cfg_d.dir  = wd; cfg_wr_hit = 1'b1; end
                OFS_DOUT:   begin cfg_d.dout = wd; cfg_wr_hit = 1'b1; end
                OFS_POL:    begin cfg_d.pol  = wd; cfg_wr_hit = 1'b1; end
                OFS_TRIG:   begin cfg_d.trig = wd; cfg_wr_hit = 1'b1; end
                OFS_BOTH:   begin cfg_d.both = wd; cfg_wr_hit = 1'b1; end
                OFS_MASK:   begin cfg_d.en = cfg_q.en & wd; cfg_wr_hit = 1'b1; end
                OFS_UNMASK: begin cfg_d.en = cfg_q.en | wd; cfg_wr_hit = 1'b1; end
                OFS_ACK:    ack = wd;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    gpio_sync #(.W(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_s)
    );

    gpio_irq_detect #(.W(NLINES)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_s),
        .mode_i   (cfg_q.mode[NLINES-1:0]),
        .pol_i    (cfg_q.pol[NLINES-1:0]),
        .trig_i   (cfg_q.trig[NLINES-1:0]),
        .both_i   (cfg_q.both[NLINES-1:0]),
        .ack_i    (ack[NLINES-1:0]),
        .status_o (stat)
    );

    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = cfg_q.mode;
            OFS_DIR:  bus_rdata = cfg_q.dir;
            OFS_DOUT: bus_rdata = cfg_q.dout;
            OFS_DIN:  bus_rdata = DW'(pin_s);
            OFS_STAT: bus_rdata = DW'(stat);
            OFS_MASK: bus_rdata = cfg_q.en;
            OFS_POL:  bus_rdata = cfg_q.pol;
            OFS_TRIG: bus_rdata = cfg_q.trig;
            OFS_BOTH: bus_rdata = cfg_q.both;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = cfg_q.dout[NLINES-1:0];
    assign pad_oe  = cfg_q.dir[NLINES-1:0] & ~cfg_q.mode[NLINES-1:0];
    assign irq_o   = |(stat & cfg_q.en[NLINES-1:0]);

    // R8
    mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK) |=> (cfg_q.en & ~$past(bus_wdata)) == '0);
    // R8
    unmask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_UNMASK) |=> (cfg_q.en & $past(wd)) == $past(wd));
    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cfg_wr_hit) |=> cfg_q == $past(cfg_q));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench cycle model
    logic [31:0] m_mode, m_dir, m_dout, m_pol, m_trig, m_both, m_en;
    logic [31:0] m_s1, m_s2, m_prev, m_stat;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NLINES(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = '0; m_dir = '0; m_dout = '0; m_pol = '0; m_trig = '0;
        m_both = '0; m_en = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
    endtask

    function automatic logic [31:0] next_stat();
        logic [31:0] q, qp, ev, ack;
        q   = m_s2 ^ m_pol;
        qp  = m_prev ^ m_pol;
        ev  = (m_both & (m_s2 ^ m_prev)) | (~m_both & q & ~qp);
        ack = (bus_wr && bus_addr == 8'h14) ? bus_wdata : '0;
        return m_mode & ((m_trig & (ev | (m_stat & ~ack))) | (~m_trig & q));
    endfunction

    task automatic model_edge();
        logic [31:0] ns;
        ns = next_stat();
        if (bus_wr) begin
            case (bus_addr)
                8'h00: m_mode = bus_wdata;
                8'h04: m_dir  = bus_wdata;
                8'h08: m_dout = bus_wdata;
                8'h18: m_en   = m_en & bus_wdata;
                8'h1C: m_en   = m_en | bus_wdata;
                8'h20: m_pol  = bus_wdata;
                8'h24: m_trig = bus_wdata;
                8'h4C: m_both = bus_wdata;
                default: ;
            endcase
        end
        m_stat = ns;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pad_in;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_model(input string req);
        logic [31:0] v;
        chk({req, " pad_oe"}, pad_oe, ~m_mode & m_dir);
        chk({req, " pad_out"}, pad_out, m_dout);
        chk({req, " irq"}, {31'd0, irq_o}, {31'd0, |(m_stat & m_en)});
        rd(8'h10, v);
        chk({req, " status"}, v, m_stat);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'h0);
        rd(8'h10, v); chk("R1 status", v, 32'h0);
        rd(8'h18, v); chk("R1 enables", v, 32'h0);

        // R11 unmapped offsets
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, v); chk("R11 unmapped read", v, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R11 mode unchanged", v, 32'h0);
        rd(8'h18, v); chk("R11 enables unchanged", v, 32'h0);

        // R2 / R12 general output
        wr(8'h04, 32'h0000_00FF);
        wr(8'h08, 32'h0000_00A5);
        chk("R2 oe", pad_oe, 32'h0000_00FF);
        chk("R2 out", pad_out, 32'h0000_00A5);
        rd(8'h04, v); chk("R12 dir readback", v, 32'h0000_00FF);
        rd(8'h14, v); chk("R7 ack reads zero", v, 32'h0);

        // R3 synchronizer latency
        pad_in = 32'h1234_5670;
        step();
        rd(8'h0C, v); chk("R3 one edge", v, 32'h0);
        step();
        rd(8'h0C, v); chk("R3 two edges", v, 32'h1234_5670);

        // R10 non-interrupt line toggling
        pad_in = 32'h0; step(); step(); step();
        rd(8'h10, v); chk("R10 idle status", v, 32'h0);

        // R5/R6 edge setup: lines 0..3 interrupt, line1 falling, line2 both
        wr(8'h24, 32'h0000_000F);
        wr(8'h20, 32'h0000_0002);
        wr(8'h4C, 32'h0000_0004);
        wr(8'h00, 32'h0000_000F);
        chk("R2 oe masked by mode", pad_oe, 32'h0000_00F0);
        rd(8'h4C, v); chk("R12 both readback", v, 32'h4);
        wr(8'h1C, 32'h0000_000F);
        rd(8'h1C, v); chk("R8 unmask reads zero", v, 32'h0);
        wr(8'h14, 32'h0000_000F);
        pad_in = 32'h0000_000F;
        step(); step();
        rd(8'h10, v); chk("R5 not yet", v, 32'h0);
        step();
        rd(8'h10, v); chk("R5 rising set", v, 32'h0000_000D);
        chk("R9 irq", {31'd0, irq_o}, 32'h1);
        pad_in = 32'h0;
        step(); step(); step();
        rd(8'h10, v); chk("R6 falling sticky", v, 32'h0000_000F);

        // R7 acknowledge
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, v); chk("R7 clear bit0", v, 32'h0000_000E);
        wr(8'h14, 32'h0);
        rd(8'h10, v); chk("R7 zero write", v, 32'h0000_000E);
        // event and clear on the same edge
        pad_in = 32'h0000_0001;
        step(); step();
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, v); chk("R7 set beats clear", v, 32'h0000_000F);
        wr(8'h14, 32'h0000_000F);
        rd(8'h10, v); chk("R7 clear all", v, 32'h0);
        chk("R9 irq low", {31'd0, irq_o}, 32'h0);

        // R4 level, active low on line 4
        wr(8'h20, 32'h0000_0012);
        wr(8'h24, 32'h0000_000F);
        wr(8'h00, 32'h0000_001F);
        step();
        rd(8'h10, v); chk("R4 level low active", v, 32'h0000_0010);
        wr(8'h14, 32'h0000_0010);
        rd(8'h10, v); chk("R4 no clear", v, 32'h0000_0010);
        pad_in = 32'h0000_0011;
        step(); step(); step();
        rd(8'h10, v); chk("R4 follows pin", v, 32'h0000_0000);

        // R8 mask register
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, v); chk("R8 mask clears zeros", v, 32'hFFFF_FFFE);
        wr(8'h18, 32'h0);
        rd(8'h18, v); chk("R8 mask all", v, 32'h0);

        // random phase against model
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            int unsigned sel;
            sel = $urandom % 12;
            pad_in = pad_in ^ ($urandom & $urandom);
            bus_wr = (sel < 9);
            case (sel)
                0: bus_addr = 8'h00;  1: bus_addr = 8'h04;
                2: bus_addr = 8'h08;  3: bus_addr = 8'h14;
                4: bus_addr = 8'h18;  5: bus_addr = 8'h1C;
                6: bus_addr = 8'h20;  7: bus_addr = 8'h24;
                default: bus_addr = 8'h4C;
            endcase
            bus_wdata = $urandom;
            if (sel == 4) bus_wdata = bus_wdata | $urandom;
            step();
            bus_wr = 1'b0;
            check_model("R9 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule